// File: doc/BRIEF.md
# CPU Interrupt Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best candidate as an ID, a priority and a valid flag. The block compares that candidate against a programmable priority mask and a control enable. When the candidate qualifies and no interrupt is already in service, it raises an interrupt line toward the processor.

The processor reaches the block through four word-sized register slots on a simple read/write port. Reading the acknowledge slot returns the ID of the qualifying candidate. That read also consumes the candidate: a one-cycle clear-pending pulse goes back to the distributor, and the candidate's priority becomes the running priority. While that interrupt is in service, no further interrupt is signalled. Service ends when the processor writes the same ID to the end-of-interrupt slot. An acknowledge with nothing to deliver returns the spurious ID 1023 and changes nothing.

Top module: `cif_cpu_port`

## Requirements
- R1: After reset, irq_out is 0, clr_pend is 0, busy_prio is all ones, and the control and mask registers read as 0.
- R2: Slot 0 is the control register. Only bits [1:0] are stored and read back, and all other bits read 0. Signalling is enabled when either stored bit is 1.
- R3: Slot 1 is the mask register. A 5-bit mask is stored from write-data bits [7:3] and read back in bits [7:3], and all other bits read 0.
- R4: irq_out rises one cycle after all four of these hold: cand_valid is 1, signalling is enabled, cand_prio is strictly less than the mask, and no interrupt is in service. A candidate whose priority equals the mask is not signalled.
- R5: A read of slot 2 while a candidate qualifies returns cand_id, zero-extended, in bus_rdata on the next cycle. In that same cycle, clr_pend is high for exactly one cycle with clr_id equal to that ID.
- R6: A read of slot 2 while no candidate qualifies returns 1023. It raises no clr_pend pulse and leaves busy_prio unchanged.
- R7: After a successful acknowledge, busy_prio equals the acknowledged priority. irq_out then stays 0, even while a qualifying candidate is present, until that interrupt is completed.
- R8: A write to slot 3 whose low 10 bits match the in-service ID ends service. busy_prio then returns to all ones, and signalling resumes on the following cycle.
- R9: A write to slot 3 carrying any other ID is ignored: the interrupt stays in service and irq_out stays 0.
- R10: Writes to slot 2 change neither the control register nor the mask register. Reads of slot 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | ID_W | Candidate interrupt ID |
| cand_prio | input | PRIO_W | Candidate priority, lower value is more urgent |
| bus_addr | input | 2 | Register slot select |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq_out | output | 1 | Interrupt request to the processor |
| clr_pend | output | 1 | One-cycle clear-pending pulse to the distributor |
| clr_id | output | ID_W | ID to clear with clr_pend |
| busy_prio | output | PRIO_W | Running priority, all ones when idle |

## Verification
The bench targets the strict mask comparison. A design that used less-or-equal would signal a candidate whose priority equals the mask. It probes an acknowledge with nothing pending, where a faulty design would emit a clear pulse or enter service with a stale ID. It writes a wrong completion ID, which a careless design would accept and so reopen signalling early. It also checks that the line stays low while an interrupt is in service, even with a more urgent candidate waiting.

// File: rtl/cif_pkg.sv
package cif_pkg;
   typedef enum logic [1:0] {
      SLOT_CTRL = 2'd0,
      SLOT_MASK = 2'd1,
      SLOT_ACK  = 2'd2,
      SLOT_EOI  = 2'd3
   } cif_slot_e;

   localparam int SPURIOUS_ID = 1023;
   localparam int MASK_LSB    = 3;
   localparam int CTRL_BITS   = 2;
endpackage

// File: rtl/cif_regs.sv
module cif_regs #(
   parameter int PRIO_W = 5,
   parameter int DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_ctrl,
   input  logic                         wr_mask,
   input  logic [DATA_W-1:0]            wdata,
   output logic [cif_pkg::CTRL_BITS-1:0] ctrl_q,
   output logic [PRIO_W-1:0]            mask_q,
   output logic                         en
);
   localparam int MLO = cif_pkg::MASK_LSB;
   localparam int MHI = MLO + PRIO_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wdata[cif_pkg::CTRL_BITS-1:0];
         if (wr_mask) mask_q <= wdata[MHI:MLO];
      end
   end

   assign en = |ctrl_q;

   // R2: control holds its value unless written
   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(ctrl_q));
   // R3: mask holds its value unless written
   assert_mask_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/cif_gate.sv
module cif_gate #(
   parameter int PRIO_W  = 5,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [PRIO_W-1:0] mask,
   input  logic              cand_valid,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic              active,
   output logic              qualify,
   output logic              irq
);
   assign qualify = en && cand_valid && (cand_prio < mask) && !active;

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= qualify;
      end
   end else begin : g_comb
      assign irq = qualify;
   end

   // R7: no request while an interrupt has been in service for a cycle
   assert_hold_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> !irq);
endmodule

// File: rtl/cif_track.sv
module cif_track #(
   parameter int ID_W   = 10,
   parameter int PRIO_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack_rd,
   input  logic              qualify,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic              eoi_wr,
   input  logic [ID_W-1:0]   eoi_id,
   output logic              active,
   output logic [PRIO_W-1:0] busy_prio,
   output logic [ID_W-1:0]   ack_val,
   output logic              clr_pend,
   output logic [ID_W-1:0]   clr_id
);
   localparam logic [ID_W-1:0] SPUR = ID_W'(cif_pkg::SPURIOUS_ID);

   logic [ID_W-1:0] run_id;
   logic            take;
   logic            done;

   assign take    = ack_rd && qualify;
   assign done    = eoi_wr && active && (eoi_id == run_id);
   assign ack_val = qualify ? cand_id : SPUR;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         run_id    <= '0;
         busy_prio <= '1;
         clr_pend  <= 1'b0;
         clr_id    <= '0;
      end else begin
         clr_pend <= take;
         if (take) begin
            active    <= 1'b1;
            run_id    <= cand_id;
            busy_prio <= cand_prio;
            clr_id    <= cand_id;
         end else if (done) begin
            active    <= 1'b0;
            busy_prio <= '1;
         end
      end
   end

   // R5: a successful acknowledge pulses the clear toward the distributor
   assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && qualify) |=> (clr_pend && clr_id == $past(cand_id)));
   // R6: empty acknowledge has no side effect
   assert_spurious_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !qualify) |=> (!clr_pend && busy_prio == $past(busy_prio)));
   // R8: idle means the running priority is released
   assert_idle_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (busy_prio == '1));
   // R9: a mismatching completion leaves service in place
   assert_eoi_mismatch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && active && eoi_id != run_id && !ack_rd) |=> active);
endmodule

// File: rtl/cif_cpu_port.sv
module cif_cpu_port #(
   parameter int ID_W    = 10,
   parameter int PRIO_W  = 5,
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cand_valid,
   input  logic [ID_W-1:0]   cand_id,
   input  logic [PRIO_W-1:0] cand_prio,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_out,
   output logic              clr_pend,
   output logic [ID_W-1:0]   clr_id,
   output logic [PRIO_W-1:0] busy_prio
);
   import cif_pkg::*;

   localparam int MLO = MASK_LSB;

   if (ID_W < 10) begin : g_bad_id
      $error("ID_W must hold the spurious ID");
   end
   if (DATA_W < MLO + PRIO_W || DATA_W < ID_W) begin : g_bad_data
      $error("DATA_W too narrow for the register fields");
   end

   logic [CTRL_BITS-1:0] ctrl_q;
   logic [PRIO_W-1:0]    mask_q;
   logic                 en, qualify, active;
   logic [ID_W-1:0]      ack_val;
   logic                 wr_ctrl, wr_mask, ack_rd, eoi_wr;

   assign wr_ctrl = bus_wr && (bus_addr == SLOT_CTRL);
   assign wr_mask = bus_wr && (bus_addr == SLOT_MASK);
   assign eoi_wr  = bus_wr && (bus_addr == SLOT_EOI);
   assign ack_rd  = bus_rd && (bus_addr == SLOT_ACK);

   cif_regs #(.PRIO_W(PRIO_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_mask(wr_mask),
      .wdata(bus_wdata), .ctrl_q(ctrl_q), .mask_q(mask_q), .en(en));

   cif_gate #(.PRIO_W(PRIO_W), .OUT_REG(OUT_REG)) u_gate (
      .clk(clk), .rst_n(rst_n), .en(en), .mask(mask_q),
      .cand_valid(cand_valid), .cand_prio(cand_prio), .active(active),
      .qualify(qualify), .irq(irq_out));

   cif_track #(.ID_W(ID_W), .PRIO_W(PRIO_W)) u_track (
      .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .qualify(qualify),
      .cand_id(cand_id), .cand_prio(cand_prio), .eoi_wr(eoi_wr),
      .eoi_id(bus_wdata[ID_W-1:0]), .active(active), .busy_prio(busy_prio),
      .ack_val(ack_val), .clr_pend(clr_pend), .clr_id(clr_id));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd) begin
         case (bus_addr)
            SLOT_CTRL: bus_rdata <= DATA_W'(ctrl_q);
            SLOT_MASK: bus_rdata <= DATA_W'(mask_q) << MLO;
            SLOT_ACK:  bus_rdata <= DATA_W'(ack_val);
            default:   bus_rdata <= '0;
         endcase
      end
   end

   // R10: the completion slot reads as zero
   assert_eoi_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == SLOT_EOI) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_cif_cpu_port.sv
module sim_cif_cpu_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cand_valid = 1'b0;
   logic [9:0]  cand_id = '0;
   logic [4:0]  cand_prio = '0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out, clr_pend;
   logic [9:0]  clr_id;
   logic [4:0]  busy_prio;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   cif_cpu_port u0 (
      .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
      .cand_prio(cand_prio), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out),
      .clr_pend(clr_pend), .clr_id(clr_id), .busy_prio(busy_prio));

   // {ctrl[13:12], mask[11:7], valid[6], prio[5:1], expected irq[0]}
   localparam logic [13:0] VEC [8] = '{
      {2'd1, 5'd4,  1'b1, 5'd3,  1'b1},
      {2'd1, 5'd4,  1'b1, 5'd4,  1'b0},
      {2'd0, 5'd4,  1'b1, 5'd0,  1'b0},
      {2'd2, 5'd31, 1'b1, 5'd30, 1'b1},
      {2'd3, 5'd0,  1'b1, 5'd0,  1'b0},
      {2'd1, 5'd10, 1'b0, 5'd1,  1'b0},
      {2'd2, 5'd1,  1'b1, 5'd0,  1'b1},
      {2'd1, 5'd31, 1'b1, 5'd31, 1'b0}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d,
                     output logic p, output logic [9:0] pid);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata; p = clr_pend; pid = clr_id;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic        p;
      logic [9:0]  pid;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, irq_out}, 0);
      chk("R1 clr_pend", {31'b0, clr_pend}, 0);
      chk("R1 busy_prio", {27'b0, busy_prio}, 32'd31);
      rst_n = 1'b1;
      rd(2'd0, d, p, pid); chk("R1 ctrl", d, 0);
      rd(2'd1, d, p, pid); chk("R1 mask", d, 0);

      // R4 vector walk
      foreach (VEC[i]) begin
         wr(2'd0, {30'b0, VEC[i][13:12]});
         wr(2'd1, {24'b0, VEC[i][11:7], 3'b0});
         cand_valid = VEC[i][6]; cand_prio = VEC[i][5:1]; cand_id = 10'(i + 5);
         @(negedge clk);
         chk($sformatf("R4 vec%0d", i), {31'b0, irq_out}, {31'b0, VEC[i][0]});
      end
      cand_valid = 1'b0;

      // R2 / R3 readback of field positions
      wr(2'd0, 32'hFFFF_FFFF);
      rd(2'd0, d, p, pid); chk("R2 ctrl readback", d, 32'h3);
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd1, d, p, pid); chk("R3 mask readback", d, 32'hF8);
      // R10 slot 2 writes ignored, slot 3 reads zero
      wr(2'd2, 32'h0);
      rd(2'd0, d, p, pid); chk("R10 ctrl after slot2 write", d, 32'h3);
      rd(2'd1, d, p, pid); chk("R10 mask after slot2 write", d, 32'hF8);
      rd(2'd3, d, p, pid); chk("R10 slot3 read", d, 0);

      // R6 spurious acknowledge
      wr(2'd0, 32'h0);
      cand_valid = 1'b1; cand_id = 10'd77; cand_prio = 5'd1;
      rd(2'd2, d, p, pid);
      chk("R6 spurious id", d, 32'd1023);
      chk("R6 no pulse", {31'b0, p}, 0);
      chk("R6 busy_prio", {27'b0, busy_prio}, 32'd31);

      // R5 acknowledge
      wr(2'd0, 32'h1);
      wr(2'd1, 32'd8 << 3);
      cand_id = 10'd99; cand_prio = 5'd2;
      @(negedge clk);
      chk("R4 irq before ack", {31'b0, irq_out}, 1);
      rd(2'd2, d, p, pid);
      chk("R5 ack id", d, 32'd99);
      chk("R5 pulse", {31'b0, p}, 1);
      chk("R5 clr_id", {22'b0, pid}, 32'd99);
      @(negedge clk);
      chk("R5 pulse single", {31'b0, clr_pend}, 0);
      // R7 held low while in service
      chk("R7 busy_prio", {27'b0, busy_prio}, 32'd2);
      cand_id = 10'd50; cand_prio = 5'd0;
      @(negedge clk);
      chk("R7 irq low", {31'b0, irq_out}, 0);
      rd(2'd2, d, p, pid);
      chk("R7 second ack spurious", d, 32'd1023);
      chk("R7 second ack no pulse", {31'b0, p}, 0);

      // R9 wrong completion ignored
      wr(2'd3, 32'd98);
      @(negedge clk);
      chk("R9 irq low", {31'b0, irq_out}, 0);
      chk("R9 busy_prio", {27'b0, busy_prio}, 32'd2);

      // R8 matching completion (upper bits beyond ID ignored)
      wr(2'd3, 32'h463);
      chk("R8 busy_prio released", {27'b0, busy_prio}, 32'd31);
      @(negedge clk);
      chk("R8 irq resumes", {31'b0, irq_out}, 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule